// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a clocked host to a 512K x 8 asynchronous static RAM. The host issues one read or one write at a time through a valid/ready handshake. The block turns each request into the strobe sequence the memory needs: an active-low chip select, write enable and output enable, a stable address, and a data bus that is split into a driven value, a sampled value and a driver enable. Read data goes back to the host with a one-cycle valid pulse.

Every strobe phase has a length in whole clock cycles, set by a parameter. The lengths cover data setup before write enable falls, the write-enable pulse, the read access window, the bus turnaround after a read, and the wake-up recovery. With the default values at 100 MHz, both a write and a read keep chip select low for 2 cycles (20 ns). The write pulse is 10 ns long, after 10 ns of data setup, and read data is sampled 20 ns after the address is presented. A power-down input puts the memory into standby or retention with chip select high. When the input is released, a recovery counter must run out before the block takes new work.

Top module: `sram_bridge`

## Requirements
- R1: During and right after reset, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, rsp_valid is 0 and req_ready is 1.
- R2: req_ready is 1 only when no transfer is in progress, the memory is powered and pwr_down is 0. A request is accepted on a rising edge where req_valid and req_ready are both 1. While req_ready is 1, chip select is high and the data driver is off.
- R3: A write (req_write=1) keeps mem_cs_n low for SETUP_CYC+WE_CYC cycles. In the first SETUP_CYC cycles mem_we_n is 1; in the last WE_CYC cycles mem_we_n is 0. mem_oe_n stays 1 and mem_dq_oe stays 1 for the whole write. Afterwards chip select and write enable return to 1 together.
- R4: For as long as chip select is low, mem_addr holds the accepted address. For as long as the driver is on, mem_dq_out holds the accepted write data.
- R5: A read (req_write=0) keeps mem_cs_n and mem_oe_n low, mem_we_n high and mem_dq_oe off for RD_CYC cycles. In the cycle after that, rsp_valid is 1 and rsp_rdata equals the value on mem_dq_in in the last read cycle.
- R6: mem_dq_oe is never 1 while mem_oe_n is 0, and mem_we_n is never 0 while mem_cs_n is 1.
- R7: A write accepted after a completed read first spends TURN_CYC cycles with all strobes high and the driver off.
- R8: While the memory is asleep, mem_cs_n and mem_oe_n are 1 and req_ready is 0. A request held valid during this time is not accepted.
- R9: After pwr_down falls, req_ready stays 0 for max(RECOV_CYC, RD_CYC) cycles and then returns to 1.
- R10: If pwr_down rises while a transfer is in progress, the transfer completes in full with its normal strobes. The block then enters sleep.
- R11: rsp_valid is a single-cycle pulse, given exactly once for each read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DATA_W | Read data |
| pwr_down | input | 1 | Request standby / retention |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Data driven to memory |
| mem_dq_in | input | DATA_W | Data sampled from memory |
| mem_dq_oe | output | 1 | Host data driver enable |

## Verification
The assertions assume that the host changes req_addr, req_wdata and req_write only while it is not being accepted. They also assume that pwr_down follows the idle rule, and that mem_dq_in carries the memory's value whenever chip select and output enable are both low. The bench drives every input just after a falling edge, raises pwr_down only when req_ready shows the block is idle (or on purpose during a write, to test R10), and models the memory so that it returns stored words only under those strobes. The sweeps use a 16-word configuration, so every address is written, read back and written again after a read.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_TURN,
        BUS_WSETUP,
        BUS_WPULSE,
        BUS_READ
    } bus_state_e;

    typedef enum logic [1:0] {
        PWR_ON,
        PWR_SLEEP,
        PWR_RECOV
    } pwr_state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drv;
    } pin_ctl_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Strobe levels for each bus phase; idle and turnaround leave the memory deselected.
    function automatic pin_ctl_t pins_for(input bus_state_e s);
        pin_ctl_t p;
        p = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
        case (s)
            BUS_WSETUP: p = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b1};
            BUS_WPULSE: p = '{cs_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drv: 1'b1};
            BUS_READ:   p = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drv: 1'b0};
            default:    p = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_pwr_seq.sv
module sram_pwr_seq
    import sram_bridge_pkg::*;
#(
    parameter int CNT_W      = 2,
    parameter int RECOV_LOAD = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic pd,
    input  logic bus_idle,
    output logic avail,
    output logic asleep
);
    pwr_state_e state_q, state_d;
    logic       tmr_load, tmr_last;

    sram_phase_timer #(.CNT_W(CNT_W)) u_recov_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (CNT_W'(RECOV_LOAD)),
        .last     (tmr_last)
    );

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        case (state_q)
            PWR_ON:    if (pd && bus_idle) state_d = PWR_SLEEP;
            PWR_SLEEP: if (!pd) begin
                           state_d  = PWR_RECOV;
                           tmr_load = 1'b1;
                       end
            PWR_RECOV: if (tmr_last) state_d = PWR_ON;
            default:   state_d = PWR_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PWR_ON;
        else     state_q <= state_d;
    end

    assign avail  = (state_q == PWR_ON);
    assign asleep = (state_q == PWR_SLEEP);

    // R9: leaving sleep always passes through recovery before becoming available
    assert_wake_via_recov_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == PWR_SLEEP) |-> (state_q != PWR_ON));
endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              sample,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (capture) begin
            mem_addr   <= cap_addr;
            mem_dq_out <= cap_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= sample;
            if (sample) rd_data <= mem_dq_in;
        end
    end

    // R11: read data valid never lasts two cycles
    assert_rvalid_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
    import sram_bridge_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 8,
    parameter int SETUP_CYC = 1,
    parameter int WE_CYC    = 1,
    parameter int RD_CYC    = 2,
    parameter int TURN_CYC  = 1,
    parameter int RECOV_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              pwr_down,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int RECOV_EFF = max2(RECOV_CYC, RD_CYC);
    localparam int MAXC      = max2(max2(max2(SETUP_CYC, WE_CYC), max2(RD_CYC, TURN_CYC)), RECOV_EFF);
    localparam int CNT_W     = cnt_bits(MAXC);
    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WE    = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RD    = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TURN  = CNT_W'(max2(TURN_CYC - 1, 0));
    localparam bit               USE_TURN = (TURN_CYC > 0);

    bus_state_e       state_q, state_d;
    logic             after_read_q;
    logic             accept, sample, ph_load, ph_last;
    logic [CNT_W-1:0] ph_val;
    logic             avail, asleep;
    pin_ctl_t         pins;

    assign req_ready = (state_q == BUS_IDLE) && avail && !pwr_down;
    assign accept    = req_valid && req_ready;

    sram_phase_timer #(.CNT_W(CNT_W)) u_phase_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (ph_load),
        .load_val (ph_val),
        .last     (ph_last)
    );

    sram_pwr_seq #(.CNT_W(CNT_W), .RECOV_LOAD(RECOV_EFF - 1)) u_pwr (
        .clk      (clk),
        .rst      (rst),
        .pd       (pwr_down),
        .bus_idle (state_q == BUS_IDLE),
        .avail    (avail),
        .asleep   (asleep)
    );

    sram_dq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dq (
        .clk        (clk),
        .rst        (rst),
        .capture    (accept),
        .cap_addr   (req_addr),
        .cap_data   (req_wdata),
        .sample     (sample),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rd_data    (rsp_rdata),
        .rd_valid   (rsp_valid)
    );

    always_comb begin
        state_d = state_q;
        ph_load = 1'b0;
        ph_val  = '0;
        sample  = 1'b0;
        case (state_q)
            BUS_IDLE: if (accept) begin
                ph_load = 1'b1;
                if (!req_write) begin
                    state_d = BUS_READ;
                    ph_val  = LD_RD;
                end else if (after_read_q && USE_TURN) begin
                    state_d = BUS_TURN;
                    ph_val  = LD_TURN;
                end else begin
                    state_d = BUS_WSETUP;
                    ph_val  = LD_SETUP;
                end
            end
            BUS_TURN: if (ph_last) begin
                state_d = BUS_WSETUP;
                ph_load = 1'b1;
                ph_val  = LD_SETUP;
            end
            BUS_WSETUP: if (ph_last) begin
                state_d = BUS_WPULSE;
                ph_load = 1'b1;
                ph_val  = LD_WE;
            end
            BUS_WPULSE: if (ph_last) state_d = BUS_IDLE;
            BUS_READ: if (ph_last) begin
                state_d = BUS_IDLE;
                sample  = 1'b1;
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= BUS_IDLE;
            after_read_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (sample)
                after_read_q <= 1'b1;
            else if (accept && req_write)
                after_read_q <= 1'b0;
        end
    end

    assign pins      = pins_for(state_q);
    assign mem_cs_n  = pins.cs_n;
    assign mem_we_n  = pins.we_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_dq_oe = pins.drv;

    // R6: host driver and memory outputs never both on
    assert_no_contention_R6: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);
    // R6: write enable only inside chip select
    assert_we_in_cs_R6: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_cs_n);
    // R3: output enable high during the write pulse
    assert_write_oe_high_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe));
    // R4: address stable while selected
    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));
    // R4: driven data stable while driver on
    assert_data_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));
    // R2: ready only when the memory is deselected and undriven
    assert_ready_idle_R2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && !mem_dq_oe));
    // R7: when output enable rises the host driver is still off
    assert_turnaround_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> !mem_dq_oe);
    // R8: sleep keeps the memory deselected and the host stalled
    assert_sleep_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        asleep |-> (mem_cs_n && mem_oe_n && !req_ready));
endmodule

// File: tb/sram_bridge_tb.sv
module sram_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int WORDS = 1 << AW;
    localparam int SETUP = 1;
    localparam int WEC   = 1;
    localparam int RDC   = 2;
    localparam int TURNC = 1;
    localparam int RECOV = 2;
    localparam int RECOV_EXP = (RECOV < RDC) ? RDC : RECOV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, pwr_down = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [AW-1:0] mem_addr;

    logic [DW-1:0] chip [WORDS];
    logic [DW-1:0] expect_mem [WORDS];
    int  checks = 0, errors = 0;
    bit  last_rd = 1'b0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_bridge #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SETUP), .WE_CYC(WEC),
                  .RD_CYC(RDC), .TURN_CYC(TURNC), .RECOV_CYC(RECOV)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pwr_down(pwr_down),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe));

    // Memory model: stores on a clock edge inside the write pulse, returns data only when read-enabled
    always @(posedge clk)
        if (!mem_cs_n && !mem_we_n && mem_dq_oe) chip[mem_addr] <= mem_dq_out;
    assign mem_dq_in = (!mem_cs_n && !mem_oe_n) ? chip[mem_addr] : 8'hA5;

    function automatic logic [3:0] pin_vec();
        return {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit pd_mid);
        bit ok_pins = 1'b1, ok_hold = 1'b1, ok_rdy = 1'b1;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (pd_mid) pwr_down = 1'b1;
        if (last_rd) begin
            chk(pin_vec() == 4'b1110, "R7 turnaround cycle", pin_vec(), 4'b1110);
            @(negedge clk);
        end
        for (int i = 0; i < SETUP; i++) begin
            ok_pins &= (pin_vec() == 4'b0111);
            ok_hold &= (mem_addr == a) && (mem_dq_out == d);
            ok_rdy  &= !req_ready;
            @(negedge clk);
        end
        for (int i = 0; i < WEC; i++) begin
            ok_pins &= (pin_vec() == 4'b0011);
            ok_hold &= (mem_addr == a) && (mem_dq_out == d);
            ok_rdy  &= !req_ready;
            @(negedge clk);
        end
        chk(ok_pins, pd_mid ? "R10 write strobes under power-down" : "R3 write strobes", pin_vec(), 0);
        chk(ok_hold, "R4 write address/data held", mem_addr, a);
        chk(ok_rdy, "R2 ready low while busy", 0, 0);
        chk(pin_vec() == 4'b1110, "R3 write end strobes", pin_vec(), 4'b1110);
        expect_mem[a] = d;
        last_rd = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        bit ok_pins = 1'b1, ok_hold = 1'b1;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < RDC; i++) begin
            ok_pins &= (pin_vec() == 4'b0100) && !rsp_valid && !req_ready;
            ok_hold &= (mem_addr == a);
            @(negedge clk);
        end
        chk(ok_pins, "R5 read strobes", pin_vec(), 4'b0100);
        chk(ok_hold, "R4 read address held", mem_addr, a);
        chk(rsp_valid && rsp_rdata == expect_mem[a], "R5 read data", rsp_rdata, expect_mem[a]);
        @(negedge clk);
        chk(!rsp_valid, "R11 valid single pulse", rsp_valid, 0);
        last_rd = 1'b1;
    endtask

    task automatic wake_and_count();
        int lows = 0;
        pwr_down = 1'b0;
        @(negedge clk);
        while (!req_ready && lows < 50) begin
            lows++;
            @(negedge clk);
        end
        chk(lows == RECOV_EXP, "R9 recovery length", lows, RECOV_EXP);
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            chip[i] = '0;
            expect_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk(pin_vec() == 4'b1110 && !rsp_valid, "R1 reset outputs", pin_vec(), 4'b1110);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && pin_vec() == 4'b1110, "R1 ready after reset", req_ready, 1);

        for (int a = 0; a < WORDS; a++) do_write(AW'(a), DW'(a * 37 + 5), 1'b0);
        for (int a = 0; a < WORDS; a++) do_read(AW'(a));
        for (int a = 0; a < WORDS; a++) begin
            do_write(AW'(a), DW'(8'hFF ^ (a * 19)), 1'b0);
            do_read(AW'(WORDS - 1 - a));
            do_read(AW'(a));
        end

        // R8: sleep while idle, with a request held valid
        pwr_down = 1'b1;
        #1;
        chk(!req_ready, "R8 ready drops with power-down", req_ready, 0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd3; req_wdata = 8'h00;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(mem_cs_n && mem_oe_n && !req_ready, "R8 asleep quiet", pin_vec(), 4'b1110);
        end
        req_valid = 1'b0;
        wake_and_count();
        do_read(4'd3);

        // R10: power-down raised during a write
        do_write(4'd9, 8'h3C, 1'b1);
        chk(!req_ready && mem_cs_n, "R10 sleep after write", req_ready, 0);
        repeat (3) @(negedge clk);
        wake_and_count();
        do_read(4'd9);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL WATCHDOG run hung actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule